// File: doc/BRIEF.md
# Interrupt Source Gateway with Enable Control

This block sits at the front of a small wired-interrupt domain. It owns the per-source state of the domain: a 3-bit sensing mode, a pending bit and an enable bit for each source, numbered from 1 to `NUM_SRC`. There is no source 0. Each source's wire passes through two flops. The sensing mode then decides whether that wire can set pending, and how: on a rising edge, on a falling edge, by mirroring an asserted level, or not at all.

Software reaches the state through a simple write/read register port. Pending and enable bits can be set or cleared with 32-bit bitmap words, where bit i of word 0 is source i. They can also be set or cleared by writing a single source number. A delivery stage downstream receives a registered vector of request flags, one per source, each meaning pending, enabled and globally enabled. When the delivery stage claims a source, it returns a clear-pending strobe carrying that source's number.

Top module: `irq_src_gate`

## Requirements
- R1: After reset, every source is inactive with pending and enable at 0. The global enable is 0, `req_o` is all zeros and `rd_data` is 0.
- R2: The source config word for source i is at byte offset 0x004 + 4·(i−1), and the mode is held in its bits [2:0]. The mode codes are 0 inactive, 1 detached, 4 rising edge, 5 falling edge, 6 level high and 7 level low. Writing the reserved codes 2 or 3 stores 0. Read data appears on `rd_data` one clock after `rd_en`, and unmapped addresses read 0.
- R3: An inactive source never becomes pending from its wire, and writes to its pending and enable bits are ignored. Writing mode 0 to a source clears both its pending and its enable bit.
- R4: A detached source ignores its wire. It becomes pending only through a software set, and it is cleared by a software clear or by the delivery strobe.
- R5: In the edge modes (4, 5), the selected edge of the registered copy of the wire sets pending. A software clear or the delivery strobe clears it. When a set and a clear land in the same cycle, pending ends up 1.
- R6: In the level modes (6, 7), pending equals the asserted level of the registered wire: the wire value for mode 6, its inverse for mode 7. Software set/clear and the delivery strobe have no effect on it.
- R7: Enable control: writing a number to 0x1EDC enables that source, and writing a number to 0x1FDC disables it. Writing a bitmap to 0x1E00 sets, and a bitmap to 0x1F00 clears, the enables of every source whose bit is 1. The enable bitmap reads back at 0x1E00.
- R8: Pending control: writing a bitmap to 0x1C00 sets pending, and a bitmap to 0x1D00 clears pending. Writing a number to 0x1CDC sets pending for that source, and a number to 0x1DDC clears it. The pending bitmap reads back at 0x1C00.
- R9: A number write of 0, or of a value above `NUM_SRC`, changes nothing. Bit 0 of any bitmap write is ignored, and bit 0 of the pending and enable bitmaps always reads 0.
- R10: The domain config word at 0x000 holds the global enable in bit 8, which can be written and read back. Bit 31 always reads 1, and all other bits read 0.
- R11: `req_o[i]` is a register that is 1 exactly when, in the previous cycle, source i was pending and enabled and the global enable was 1.
- R12: A delivery strobe (`clr_vld` with `clr_id`) clears the pending bit of that source, subject to R5 and R6. An id of 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_data | output | 32 | Read data, one cycle after `rd_en` |
| src_i | input | NUM_SRC | Interrupt wires, bit i is source i (range NUM_SRC:1) |
| clr_vld | input | 1 | Clear-pending strobe from the delivery stage |
| clr_id | input | IDW | Source number cleared by the strobe |
| req_o | output | NUM_SRC | Registered pending-and-enabled flags (range NUM_SRC:1) |

## Verification
The delivery stage's clear-pending strobe and a freshly detected edge can hit the same source in the same cycle. The bench provokes this by raising an edge-mode source's wire and then, one clock later, firing the strobe for that source, so that the strobe arrives exactly on the edge where the registered edge detector sets pending. The result is judged by reading the pending bitmap back and expecting the bit set. A lone strobe sent afterwards must then clear it.

// File: rtl/isg_pkg.sv
package isg_pkg;

  localparam int REG_W = 32;

  typedef enum logic [2:0] {
    SM_OFF    = 3'd0,
    SM_DETACH = 3'd1,
    SM_RISE   = 3'd4,
    SM_FALL   = 3'd5,
    SM_HIGH   = 3'd6,
    SM_LOW    = 3'd7
  } smode_e;

  localparam logic [15:0] OFS_DOMAIN   = 16'h0000;
  localparam logic [15:0] OFS_CFG0     = 16'h0004;
  localparam logic [15:0] OFS_PSET_MAP = 16'h1C00;
  localparam logic [15:0] OFS_PSET_NUM = 16'h1CDC;
  localparam logic [15:0] OFS_PCLR_MAP = 16'h1D00;
  localparam logic [15:0] OFS_PCLR_NUM = 16'h1DDC;
  localparam logic [15:0] OFS_ESET_MAP = 16'h1E00;
  localparam logic [15:0] OFS_ESET_NUM = 16'h1EDC;
  localparam logic [15:0] OFS_ECLR_MAP = 16'h1F00;
  localparam logic [15:0] OFS_ECLR_NUM = 16'h1FDC;

  localparam int GIE_BIT = 8;

  // reserved codes fold to inactive
  function automatic logic [2:0] legal_mode(input logic [2:0] raw);
    if (raw == 3'd2 || raw == 3'd3) return 3'd0;
    return raw;
  endfunction

endpackage

// File: rtl/isg_wr_decode.sv
module isg_wr_decode
  import isg_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int ADDR_W  = 16
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [NUM_SRC:0]  pset_o,
  output logic [NUM_SRC:0]  pclr_o,
  output logic [NUM_SRC:0]  eset_o,
  output logic [NUM_SRC:0]  eclr_o,
  output logic [NUM_SRC:0]  cfg_we_o,
  output logic              dom_we_o
);

  // bitmap word holding source idx at base, and the bit within it
  function automatic logic map_hit(input logic [ADDR_W-1:0] a,
                                   input logic [REG_W-1:0]  d,
                                   input logic [15:0]       base,
                                   input int                idx);
    return (a == ADDR_W'(base + 16'(4 * (idx / 32)))) && d[idx % 32];
  endfunction

  logic                 num_ok;
  logic [NUM_SRC:0]     num_hot;

  always_comb begin
    num_ok  = (wr_data != '0) && (wr_data <= REG_W'(NUM_SRC));
    num_hot = '0;
    for (int i = 1; i <= NUM_SRC; i++) begin
      num_hot[i] = num_ok && (wr_data == REG_W'(i));
    end
  end

  always_comb begin
    pset_o   = '0;
    pclr_o   = '0;
    eset_o   = '0;
    eclr_o   = '0;
    cfg_we_o = '0;
    for (int i = 1; i <= NUM_SRC; i++) begin
      pset_o[i] = wr_en && (map_hit(wr_addr, wr_data, OFS_PSET_MAP, i) ||
                  (wr_addr == ADDR_W'(OFS_PSET_NUM) && num_hot[i]));
      pclr_o[i] = wr_en && (map_hit(wr_addr, wr_data, OFS_PCLR_MAP, i) ||
                  (wr_addr == ADDR_W'(OFS_PCLR_NUM) && num_hot[i]));
      eset_o[i] = wr_en && (map_hit(wr_addr, wr_data, OFS_ESET_MAP, i) ||
                  (wr_addr == ADDR_W'(OFS_ESET_NUM) && num_hot[i]));
      eclr_o[i] = wr_en && (map_hit(wr_addr, wr_data, OFS_ECLR_MAP, i) ||
                  (wr_addr == ADDR_W'(OFS_ECLR_NUM) && num_hot[i]));
      cfg_we_o[i] = wr_en && (wr_addr == ADDR_W'(OFS_CFG0 + 16'(4 * (i - 1))));
    end
    dom_we_o = wr_en && (wr_addr == ADDR_W'(OFS_DOMAIN));
  end

endmodule

// File: rtl/isg_src_cell.sv
module isg_src_cell
  import isg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wire_i,
  input  logic       cfg_we,
  input  logic [2:0] cfg_raw,
  input  logic       pset,
  input  logic       pclr,
  input  logic       eset,
  input  logic       eclr,
  input  logic       dlv_clr,
  output logic [2:0] mode_o,
  output logic       pend_o,
  output logic       en_o
);

  logic [2:0] mode_q, mode_nxt;
  logic       s1_q, s2_q;
  logic       pend_q, pend_nxt;
  logic       en_q, en_nxt;
  logic       rise, fall, clr_any;

  assign rise    = s1_q & ~s2_q;
  assign fall    = ~s1_q & s2_q;
  assign clr_any = pclr | dlv_clr;

  always_comb begin
    mode_nxt = cfg_we ? legal_mode(cfg_raw) : mode_q;

    case (mode_q)
      SM_DETACH: pend_nxt = (pend_q & ~clr_any) | pset;
      SM_RISE:   pend_nxt = (pend_q & ~clr_any) | pset | rise;
      SM_FALL:   pend_nxt = (pend_q & ~clr_any) | pset | fall;
      SM_HIGH:   pend_nxt = s1_q;
      SM_LOW:    pend_nxt = ~s1_q;
      default:   pend_nxt = 1'b0;
    endcase

    if (mode_q == SM_OFF) en_nxt = 1'b0;
    else                  en_nxt = (en_q & ~eclr) | eset;

    if (mode_nxt == SM_OFF) begin
      pend_nxt = 1'b0;
      en_nxt   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= SM_OFF;
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      mode_q <= mode_nxt;
      s1_q   <= wire_i;
      s2_q   <= s1_q;
      pend_q <= pend_nxt;
      en_q   <= en_nxt;
    end
  end

  assign mode_o = mode_q;
  assign pend_o = pend_q;
  assign en_o   = en_q;

endmodule

// File: rtl/irq_src_gate.sv
module irq_src_gate
  import isg_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int ADDR_W  = 16,
  parameter int IDW     = $clog2(NUM_SRC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic [NUM_SRC:1]  src_i,
  input  logic              clr_vld,
  input  logic [IDW-1:0]    clr_id,
  output logic [NUM_SRC:1]  req_o
);

  localparam int NWORDS = (NUM_SRC + 32) / 32;
  localparam int MAPW   = NWORDS * 32;

  logic [NUM_SRC:0]         pset, pclr, eset, eclr, cfg_we, dlv_hot;
  logic                     dom_we;
  logic                     gie_q;
  logic [NUM_SRC:0]         pend_vec, en_vec;
  logic [2:0]               mode_arr [NUM_SRC:0];
  logic [3*(NUM_SRC+1)-1:0] mode_flat;
  logic [MAPW-1:0]          pend_map, en_map;
  logic [31:0]              rd_val, rd_q;
  logic [NUM_SRC:1]         req_q;

  isg_wr_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_dec (
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .pset_o   (pset),
    .pclr_o   (pclr),
    .eset_o   (eset),
    .eclr_o   (eclr),
    .cfg_we_o (cfg_we),
    .dom_we_o (dom_we)
  );

  always_comb begin
    dlv_hot = '0;
    for (int i = 1; i <= NUM_SRC; i++) begin
      dlv_hot[i] = clr_vld && (clr_id == IDW'(i));
    end
  end

  assign pend_vec[0]  = 1'b0;
  assign en_vec[0]    = 1'b0;
  assign mode_arr[0]  = 3'd0;
  assign mode_flat[2:0] = 3'd0;

  for (genvar g = 1; g <= NUM_SRC; g++) begin : g_src
    isg_src_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .wire_i  (src_i[g]),
      .cfg_we  (cfg_we[g]),
      .cfg_raw (wr_data[2:0]),
      .pset    (pset[g]),
      .pclr    (pclr[g]),
      .eset    (eset[g]),
      .eclr    (eclr[g]),
      .dlv_clr (dlv_hot[g]),
      .mode_o  (mode_arr[g]),
      .pend_o  (pend_vec[g]),
      .en_o    (en_vec[g])
    );
    assign mode_flat[3*g +: 3] = mode_arr[g];
  end

  always_ff @(posedge clk) begin
    if (rst)         gie_q <= 1'b0;
    else if (dom_we) gie_q <= wr_data[GIE_BIT];
  end

  always_comb begin
    pend_map = '0;
    en_map   = '0;
    pend_map[NUM_SRC:0] = pend_vec;
    en_map[NUM_SRC:0]   = en_vec;
  end

  always_comb begin
    rd_val = '0;
    if (rd_addr == ADDR_W'(OFS_DOMAIN)) begin
      rd_val[31]      = 1'b1;
      rd_val[GIE_BIT] = gie_q;
    end
    for (int w = 0; w < NWORDS; w++) begin
      if (rd_addr == ADDR_W'(OFS_PSET_MAP + 16'(4 * w))) rd_val = pend_map[32*w +: 32];
      if (rd_addr == ADDR_W'(OFS_ESET_MAP + 16'(4 * w))) rd_val = en_map[32*w +: 32];
    end
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (rd_addr == ADDR_W'(OFS_CFG0 + 16'(4 * (i - 1)))) rd_val = {29'd0, mode_arr[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      req_q <= '0;
    end else begin
      rd_q  <= rd_en ? rd_val : 32'd0;
      req_q <= pend_vec[NUM_SRC:1] & en_vec[NUM_SRC:1] & {NUM_SRC{gie_q}};
    end
  end

  assign rd_data = rd_q;
  assign req_o   = req_q;

endmodule

// File: rtl/isg_chk.sv
module isg_chk
  import isg_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int ADDR_W  = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_en,
  input logic [ADDR_W-1:0]        wr_addr,
  input logic [31:0]              wr_data,
  input logic                     rd_en,
  input logic [ADDR_W-1:0]        rd_addr,
  input logic [31:0]              rd_data,
  input logic [NUM_SRC:1]         src_i,
  input logic                     clr_vld,
  input logic [NUM_SRC:1]         req_o,
  input logic                     gie_q,
  input logic [3*(NUM_SRC+1)-1:0] mode_flat,
  input logic [NUM_SRC:0]         pend_vec,
  input logic [NUM_SRC:0]         en_vec
);

  AST_DOMAIN_TOPBIT: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == ADDR_W'(OFS_DOMAIN)) |=> rd_data[31]);  // R10

  AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
    !gie_q |=> (req_o == '0));  // R11

  AST_BAD_NUM_NOOP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(OFS_ESET_NUM) &&
     (wr_data == 32'd0 || wr_data > 32'(NUM_SRC))) |=> $stable(en_vec));  // R9

  for (genvar g = 1; g <= NUM_SRC; g++) begin : g_chk
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
      (mode_flat[3*g +: 3] == SM_OFF) |-> (!pend_vec[g] && !en_vec[g]));  // R3

    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
      (mode_flat[3*g +: 3] == SM_HIGH && $past(mode_flat[3*g +: 3]) == SM_HIGH)
        |-> (pend_vec[g] == $past(src_i[g], 2)));  // R6

    AST_DETACH_WIRE_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (mode_flat[3*g +: 3] == SM_DETACH && $past(mode_flat[3*g +: 3]) == SM_DETACH &&
       !$past(wr_en) && !$past(clr_vld)) |-> $stable(pend_vec[g]));  // R4
  end

endmodule

bind irq_src_gate isg_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/irq_src_gate_tb.sv
`timescale 1ns/1ps
module irq_src_gate_tb;

  localparam int N = 31;
  localparam logic [15:0] A_DOM  = 16'h0000;
  localparam logic [15:0] A_PSM  = 16'h1C00;
  localparam logic [15:0] A_PSN  = 16'h1CDC;
  localparam logic [15:0] A_PCM  = 16'h1D00;
  localparam logic [15:0] A_PCN  = 16'h1DDC;
  localparam logic [15:0] A_ESM  = 16'h1E00;
  localparam logic [15:0] A_ESN  = 16'h1EDC;
  localparam logic [15:0] A_ECM  = 16'h1F00;
  localparam logic [15:0] A_ECN  = 16'h1FDC;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [N:1]  src_w = '0;
  logic        clr_vld = 1'b0;
  logic [4:0]  clr_id = '0;
  logic [N:1]  req_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  int m_mode [32];
  bit m_pend [32];
  bit m_en   [32];
  bit m_lvl  [32];
  bit m_gie;

  always #4 clk = ~clk;

  irq_src_gate u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .src_i(src_w),
    .clr_vld(clr_vld), .clr_id(clr_id), .req_o(req_o)
  );

  function automatic int fold_mode(input logic [2:0] raw);
    return (raw == 3'd2 || raw == 3'd3) ? 0 : int'(raw);
  endfunction

  function automatic bit is_level(input int m);
    return m == 6 || m == 7;
  endfunction

  function automatic logic [31:0] exp_pend();
    logic [31:0] v = '0;
    for (int i = 1; i <= N; i++) v[i] = m_pend[i];
    return v;
  endfunction

  function automatic logic [31:0] exp_en();
    logic [31:0] v = '0;
    for (int i = 1; i <= N; i++) v[i] = m_en[i];
    return v;
  endfunction

  function automatic logic [31:0] exp_req();
    logic [31:0] v = '0;
    for (int i = 1; i <= N; i++) v[i] = m_pend[i] & m_en[i] & m_gie;
    return v;
  endfunction

  task automatic mdl_wr(input logic [15:0] a, input logic [31:0] d);
    bit num_ok = (d != 0) && (d <= N);
    for (int i = 1; i <= N; i++) begin
      bit ps = (a == A_PSM && d[i]) || (a == A_PSN && num_ok && d == i);
      bit pc = (a == A_PCM && d[i]) || (a == A_PCN && num_ok && d == i);
      bit es = (a == A_ESM && d[i]) || (a == A_ESN && num_ok && d == i);
      bit ec = (a == A_ECM && d[i]) || (a == A_ECN && num_ok && d == i);
      if (a == 16'(16'h0004 + 4 * (i - 1))) begin
        int nm = fold_mode(d[2:0]);
        m_mode[i] = nm;
        if (nm == 0) begin
          m_pend[i] = 1'b0;
          m_en[i]   = 1'b0;
        end else if (nm == 6) m_pend[i] = m_lvl[i];
        else if (nm == 7)     m_pend[i] = !m_lvl[i];
      end else if (m_mode[i] != 0) begin
        m_en[i] = (m_en[i] & !ec) | es;
        if (!is_level(m_mode[i])) m_pend[i] = (m_pend[i] & !pc) | ps;
      end
    end
    if (a == A_DOM) m_gie = d[8];
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    mdl_wr(a, d);
  endtask

  task automatic do_rd(input logic [15:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic do_clr(input int id);
    @(negedge clk);
    clr_vld = 1'b1; clr_id = 5'(id);
    @(negedge clk);
    clr_vld = 1'b0;
    @(negedge clk);
    if (id >= 1 && id <= N && !is_level(m_mode[id]) && m_mode[id] != 0) m_pend[id] = 1'b0;
  endtask

  task automatic set_wire(input int i, input bit v);
    bit old = m_lvl[i];
    @(negedge clk);
    src_w[i] = v;
    repeat (3) @(negedge clk);
    m_lvl[i] = v;
    if (m_mode[i] == 4 && !old && v) m_pend[i] = 1'b1;
    if (m_mode[i] == 5 && old && !v) m_pend[i] = 1'b1;
    if (m_mode[i] == 6) m_pend[i] = v;
    if (m_mode[i] == 7) m_pend[i] = !v;
  endtask

  task automatic chk_state(input string tag);
    logic [31:0] v;
    do_rd(A_PSM, v);
    chk({tag, " pending"}, v, exp_pend());
    do_rd(A_ESM, v);
    chk({tag, " enable"}, v, exp_en());
    chk({tag, " req R11"}, {req_o, 1'b0}, exp_req());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    for (int i = 0; i < 32; i++) begin
      m_mode[i] = 0; m_pend[i] = 0; m_en[i] = 0; m_lvl[i] = 0;
    end
    m_gie = 0;

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 rd_data after reset", rd_data, 32'd0);
    chk("R1 req_o after reset", {req_o, 1'b0}, 32'd0);
    do_rd(16'h0004, v);
    chk("R1 cfg of source 1", v, 32'd0);
    do_rd(A_DOM, v);
    chk("R1 R10 domain word", v, 32'h8000_0000);
    chk_state("R1");

    // R2 mode codes and reserved folding
    do_wr(16'h0008, 32'd4);
    do_rd(16'h0008, v);
    chk("R2 cfg rise readback", v, 32'd4);
    do_wr(16'h0008, 32'hFFFF_FFF3);
    do_rd(16'h0008, v);
    chk("R2 reserved code folds to 0", v, 32'd0);
    do_wr(16'h0008, 32'd7);
    do_rd(16'h0008, v);
    chk("R2 level-low readback", v, 32'd7);
    do_wr(16'h0008, 32'd0);
    do_rd(16'h1234, v);
    chk("R2 unmapped reads 0", v, 32'd0);

    // R10 domain word
    do_wr(A_DOM, 32'hFFFF_FFFF);
    do_rd(A_DOM, v);
    chk("R10 global enable set", v, 32'h8000_0100);

    // R5 rising edge and collision with the delivery strobe
    do_wr(16'h000C, 32'd4);
    do_wr(A_ESN, 32'd3);
    @(negedge clk);
    src_w[3] = 1'b1;
    @(negedge clk);
    clr_vld = 1'b1; clr_id = 5'd3;
    @(negedge clk);
    clr_vld = 1'b0;
    repeat (2) @(negedge clk);
    m_lvl[3] = 1'b1; m_pend[3] = 1'b1;
    chk_state("R5 edge set wins over strobe");
    do_clr(3);
    chk_state("R5 R12 strobe clears edge pending");
    do_clr(0);
    chk_state("R12 id 0 no effect");

    // R5 falling edge
    do_wr(16'h0010, 32'd5);
    set_wire(4, 1'b1);
    chk_state("R5 fall ignores rising");
    set_wire(4, 1'b0);
    chk_state("R5 fall sets pending");
    do_wr(A_PCM, 32'h0000_0010);
    chk_state("R5 R8 bitmap clear");

    // R6 level high / low
    do_wr(16'h0014, 32'd6);
    do_wr(A_ESN, 32'd5);
    set_wire(5, 1'b1);
    chk_state("R6 level high pending");
    do_wr(A_PCN, 32'd5);
    chk_state("R6 sw clear ignored");
    do_clr(5);
    chk_state("R6 strobe ignored");
    set_wire(5, 1'b0);
    chk_state("R6 level drop");
    do_wr(A_PSN, 32'd5);
    chk_state("R6 sw set ignored");
    do_wr(16'h0018, 32'd7);
    chk_state("R6 level low asserted");

    // R4 detached
    do_wr(16'h001C, 32'd1);
    set_wire(7, 1'b1);
    chk_state("R4 wire ignored");
    do_wr(A_PSN, 32'd7);
    do_wr(A_ESN, 32'd7);
    set_wire(7, 1'b0);
    chk_state("R4 sw set holds");
    do_clr(7);
    chk_state("R4 strobe clears");

    // R3 inactive
    do_wr(A_PSN, 32'd8);
    do_wr(A_ESN, 32'd8);
    set_wire(8, 1'b1);
    chk_state("R3 inactive ignores all");
    do_wr(16'h0020, 32'd5);
    do_wr(A_PSN, 32'd9);
    do_wr(A_ESN, 32'd9);
    chk_state("R8 number set");
    do_wr(16'h0020, 32'd0);
    chk_state("R3 writing inactive clears");

    // R9 / R7 enables
    do_wr(16'h0024, 32'd1);
    do_wr(A_ESN, 32'd0);
    do_wr(A_ESN, 32'd32);
    chk_state("R9 bad numbers");
    do_wr(A_PSM, 32'h0000_0001);
    chk_state("R9 bitmap bit 0");
    do_wr(A_ESM, 32'hFFFF_FFFF);
    chk_state("R7 bitmap enable");
    do_wr(A_ECN, 32'd3);
    chk_state("R7 number disable");
    do_wr(A_ECM, 32'hFFFF_FFFF);
    chk_state("R7 bitmap disable all");

    // R11 global enable gating
    do_wr(A_ESM, 32'hFFFF_FFFF);
    do_wr(A_DOM, 32'd0);
    chk_state("R11 global off");
    do_wr(A_DOM, 32'h0000_0100);
    chk_state("R11 global on");

    // random phase: quiesce, fix wires, then random writes and strobes
    for (int i = 1; i <= N; i++) do_wr(16'(16'h0004 + 4 * (i - 1)), 32'd0);
    @(negedge clk);
    src_w = N'($urandom);
    repeat (3) @(negedge clk);
    for (int i = 1; i <= N; i++) m_lvl[i] = src_w[i];

    for (int it = 0; it < 200; it++) begin
      int op = $urandom % 7;
      int s  = 1 + ($urandom % N);
      case (op)
        1: begin
          int k = $urandom % 4;
          logic [15:0] a = (k == 0) ? A_PSN : (k == 1) ? A_PCN : (k == 2) ? A_ESN : A_ECN;
          do_wr(a, 32'($urandom % 34));
        end
        2: begin
          int k = $urandom % 4;
          logic [15:0] a = (k == 0) ? A_PSM : (k == 1) ? A_PCM : (k == 2) ? A_ESM : A_ECM;
          do_wr(a, $urandom);
        end
        3: do_wr(A_DOM, $urandom);
        4: do_clr($urandom % 32);
        default: do_wr(16'(16'h0004 + 4 * (s - 1)), $urandom);
      endcase
      chk_state("R3 R4 R5 R6 R7 R8 R9 R12 random");
      do_rd(16'(16'h0004 + 4 * (s - 1)), v);
      chk("R2 random cfg readback", v, 32'(m_mode[s]));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule